// File: doc/BRIEF.md
# Manchester Sync Encoder

This block builds Manchester II words from a serial NRZ stream. Each word is 20 bit times long. It opens with a three-bit-time sync pattern that marks the word as a command word or a data word. Sixteen data bits follow, and an odd parity bit closes the word. The block requests its payload from an outside shift register. It raises a request strobe and produces a shift clock, and it samples the serial input on that clock's rising edge.

A single encoder clock at twelve times the bit rate drives everything. A divide-by-six stage yields the half-bit rate, which is exposed. A following divide-by-two stage yields the bit-rate shift clock. The line appears as two active-low bipolar outputs. One is low while the line is in its positive state and the other is low while it is negative. An enable input starts a word. An inhibit input parks both outputs high at once.

Top module: `manch_sync_encoder`

## Requirements
- R1: A synchronous master reset (`rst` high at a clock edge) clears both divider stages and ends any word. While reset is held and afterwards until a word starts, both line outputs are high and `send_data_o` is low.
- R2: Let n be the number of clock edges since reset was released. `div6_o` is high exactly when n mod 6 < 3. `shift_clk_o` is high exactly when (n div 6) mod 2 = 1.
- R3: A word starts at the first edge with n a nonzero multiple of 12 at which `enable_i` is high. The word lasts 240 cycles, made of 40 half-bits of 6 cycles each.
- R4: `cmd_sel_i` is sampled only at the start edge. A command word (sampled high) opens with 3 half-bits positive (`bip_one_n_o` low) and then 3 half-bits negative (`bip_zero_n_o` low). A data word uses the reverse order.
- R5: The 16 data bits go out most significant first in bit times 3 to 18. A one is a positive half-bit followed by a negative half-bit, and a zero is the reverse.
- R6: Bit time 19 carries a parity bit chosen so that the 16 data bits plus parity hold an odd number of ones. It is Manchester coded like a data bit.
- R7: `send_data_o` is high during bit times 2 to 17 of a word (word cycles 24 to 215). `sdi_i` is sampled at the rising edge of `shift_clk_o` in bit time b, and that sample becomes data bit b-2 (0 = most significant).
- R8: While a word is in progress, `enable_i` has no effect. If `enable_i` is high at the final bit boundary, the next word starts there with no gap.
- R9: Between words, both line outputs stay high.
- R10: While `drive_en_i` is low, both line outputs are high in the same cycle, whatever word is in progress. Timing of the word is unaffected.
- R11: The two line outputs are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock, 12x the bit rate |
| rst | input | 1 | Synchronous active-high master reset |
| enable_i | input | 1 | Request to start a word at the next bit boundary |
| cmd_sel_i | input | 1 | High: command sync, low: data sync |
| sdi_i | input | 1 | Serial NRZ payload from the outside shift register |
| drive_en_i | input | 1 | Low forces both line outputs high |
| div6_o | output | 1 | Divide-by-six output, twice the bit rate |
| shift_clk_o | output | 1 | Bit-rate shift clock; payload sampled on its rising edge |
| send_data_o | output | 1 | High while the outside source must supply bits |
| bip_one_n_o | output | 1 | Active-low positive-state line drive |
| bip_zero_n_o | output | 1 | Active-low negative-state line drive |

## Verification
The divider outputs and the line state are registered once, so they reflect the state after each edge. The bench counts edges since reset and samples every output at the following falling edge against closed-form values of that count. A word requested while idle begins on the next edge with a count that is a multiple of 12. Its half-bit h is then due in word cycles 6h to 6h+5. The bench places each payload bit on `sdi_i` only across the one edge at which bit time b's shift clock rises (word cycle 12b+6) and drives random values at all other times, so a sample taken one cycle early or late shows up as corrupt data. Inhibit is combinational and is checked in the same cycle it is applied.

// File: rtl/manch_enc_pkg.sv
package manch_enc_pkg;

    localparam int DEF_DATA_BITS    = 16;
    localparam int DEF_CLK_PER_HALF = 6;
    localparam int DEF_SYNC_BITS    = 3;

    typedef enum logic [1:0] {
        LINE_IDLE = 2'd0,
        LINE_POS  = 2'd1,
        LINE_NEG  = 2'd2
    } line_e;

    typedef struct packed {
        logic half_tick;   // last cycle of a half-bit
        logic bit_end;     // last cycle of a whole bit
        logic phase;       // 0: first half-bit, 1: second half-bit
    } timebase_t;

    typedef struct packed {
        logic active;      // a word is on the line
        logic cmd;         // sync kind latched at word start
        logic cur;         // bit currently being coded
        logic nxt;         // bit fetched for the next bit time
        logic par;         // running odd parity
    } frame_t;

    // Manchester II half-bit: a one is positive then negative.
    function automatic line_e manch_half(input logic v, input logic second);
        return (v ^ second) ? LINE_POS : LINE_NEG;
    endfunction

endpackage

// File: rtl/manch_enc_divider.sv
module manch_enc_divider
    import manch_enc_pkg::*;
#(
    parameter int DIV = DEF_CLK_PER_HALF
) (
    input  logic      clk,
    input  logic      rst,
    output timebase_t tb,
    output logic      div_o
);
    localparam int            CW   = $clog2(DIV);
    localparam logic [CW-1:0] TOP  = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] cnt;
    logic          phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == TOP) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    always_comb begin
        tb.half_tick = (cnt == TOP);
        tb.bit_end   = (cnt == TOP) && phase;
        tb.phase     = phase;
        div_o        = (cnt < HALF);
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt != TOP) |=> $stable(phase));

endmodule

// File: rtl/manch_enc_framer.sv
module manch_enc_framer
    import manch_enc_pkg::*;
#(
    parameter int DATA_BITS = DEF_DATA_BITS,
    parameter int SYNC_BITS = DEF_SYNC_BITS
) (
    input  logic      clk,
    input  logic      rst,
    input  timebase_t tb,
    input  logic      enable_i,
    input  logic      cmd_sel_i,
    input  logic      sdi_i,
    output line_e     level_o,
    output logic      send_data_o
);
    localparam int            LAST      = SYNC_BITS + DATA_BITS;
    localparam int            IW        = $clog2(LAST + 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(LAST);
    localparam logic [IW-1:0] IDX_D0    = IW'(SYNC_BITS);
    localparam logic [IW-1:0] IDX_FIRST = IW'(SYNC_BITS - 1);
    localparam logic [IW-1:0] IDX_FLAST = IW'(LAST - 2);
    localparam logic [IW:0]   SYNC_MID  = (IW + 1)'(SYNC_BITS);

    frame_t        st;
    logic [IW-1:0] idx;
    logic [IW-1:0] idx_inc;
    logic [IW:0]   sync_half;
    logic          fetch;

    assign idx_inc   = idx + 1'b1;
    assign sync_half = {idx, tb.phase};
    assign fetch     = st.active && (idx >= IDX_FIRST) && (idx <= IDX_FLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            idx <= '0;
        end else begin
            // rising edge of the shift clock: take the next payload bit
            if (tb.half_tick && !tb.phase && fetch) begin
                st.nxt <= sdi_i;
                st.par <= st.par ^ sdi_i;
            end
            if (tb.bit_end) begin
                if (!st.active || idx == IDX_LAST) begin
                    st.active <= enable_i;
                    st.cmd    <= cmd_sel_i;
                    st.par    <= 1'b1;
                    idx       <= '0;
                end else begin
                    idx <= idx_inc;
                    if (idx_inc == IDX_LAST)
                        st.cur <= st.par;
                    else if (idx_inc >= IDX_D0)
                        st.cur <= st.nxt;
                end
            end
        end
    end

    always_comb begin
        if (!st.active)
            level_o = LINE_IDLE;
        else if (idx < IDX_D0)
            level_o = ((sync_half < SYNC_MID) == st.cmd) ? LINE_POS : LINE_NEG;
        else
            level_o = manch_half(st.cur, tb.phase);
        send_data_o = fetch;
    end

    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && idx != IDX_LAST) |=>
            (st.active && (idx == $past(idx) || idx == $past(idx) + 1'b1)));

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st.active && !tb.bit_end) |=> $stable(st.cmd));

    // R7
    fetch_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(send_data_o) |-> (!tb.phase && !tb.half_tick));

endmodule

// File: rtl/manch_enc_line.sv
module manch_enc_line
    import manch_enc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_e level_i,
    input  logic  drive_en_i,
    output logic  one_n_o,
    output logic  zero_n_o
);
    always_comb begin
        one_n_o  = !(drive_en_i && level_i == LINE_POS);
        zero_n_o = !(drive_en_i && level_i == LINE_NEG);
    end

    // R11
    never_both_chk: assert property (@(posedge clk) disable iff (rst)
        (one_n_o || zero_n_o));

    // R10
    inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        !drive_en_i |-> (one_n_o && zero_n_o));

endmodule

// File: rtl/manch_sync_encoder.sv
module manch_sync_encoder
    import manch_enc_pkg::*;
#(
    parameter int DATA_BITS    = DEF_DATA_BITS,
    parameter int CLK_PER_HALF = DEF_CLK_PER_HALF,
    parameter int SYNC_BITS    = DEF_SYNC_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic enable_i,
    input  logic cmd_sel_i,
    input  logic sdi_i,
    input  logic drive_en_i,
    output logic div6_o,
    output logic shift_clk_o,
    output logic send_data_o,
    output logic bip_one_n_o,
    output logic bip_zero_n_o
);
    timebase_t tb;
    line_e     level;

    manch_enc_divider #(.DIV(CLK_PER_HALF)) u_div (
        .clk   (clk),
        .rst   (rst),
        .tb    (tb),
        .div_o (div6_o)
    );

    manch_enc_framer #(.DATA_BITS(DATA_BITS), .SYNC_BITS(SYNC_BITS)) u_frm (
        .clk         (clk),
        .rst         (rst),
        .tb          (tb),
        .enable_i    (enable_i),
        .cmd_sel_i   (cmd_sel_i),
        .sdi_i       (sdi_i),
        .level_o     (level),
        .send_data_o (send_data_o)
    );

    manch_enc_line u_line (
        .clk        (clk),
        .rst        (rst),
        .level_i    (level),
        .drive_en_i (drive_en_i),
        .one_n_o    (bip_one_n_o),
        .zero_n_o   (bip_zero_n_o)
    );

    assign shift_clk_o = tb.phase;

    // R9
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        (level == LINE_IDLE) |-> (bip_one_n_o && bip_zero_n_o && !send_data_o));

endmodule

// File: tb/sim_manch_sync_encoder.sv
module sim_manch_sync_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int BITC       = 2 * HALF;
    localparam int WORD       = 20 * BITC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0, cmd_sel = 1'b0, sdi = 1'b0, drive_en = 1'b1;
    logic div6, shclk, send_data, one_n, zero_n;

    int  n = 0;
    int  vectors = 0;
    int  fails = 0;
    bit  chained = 0;
    int  next_s = 0;

    manch_sync_encoder u0 (
        .clk(clk), .rst(rst), .enable_i(enable), .cmd_sel_i(cmd_sel),
        .sdi_i(sdi), .drive_en_i(drive_en), .div6_o(div6),
        .shift_clk_o(shclk), .send_data_o(send_data),
        .bip_one_n_o(one_n), .bip_zero_n_o(zero_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s at n=%0d: actual %b expected %b", req, what, n, got, exp);
        end
    endtask

    task automatic check_clocks();
        chk(div6, (n % 6) < 3, "R2", "div6_o");
        chk(shclk, ((n / 6) % 2) == 1, "R2", "shift_clk_o");
    endtask

    task automatic check_idle(input string req);
        chk(one_n, 1'b1, req, "bip_one_n_o idle");
        chk(zero_n, 1'b1, req, "bip_zero_n_o idle");
        chk(send_data, 1'b0, req, "send_data_o idle");
    endtask

    task automatic idle_cycles(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            check_clocks();
            check_idle("R9");
            sdi = 1'($urandom);
        end
    endtask

    task automatic send_word(input logic [15:0] d, input bit cmd, input bit keep,
                             input bit pulse, input bit inh);
        int  s;
        bit  par;
        par = ~^d;
        s = chained ? next_s : (n / BITC + 1) * BITC;
        enable  = 1'b1;
        cmd_sel = cmd;
        while (n < s) begin
            @(negedge clk);
            check_clocks();
            if (n < s) check_idle("R9");
        end
        for (int t = 0; t < WORD; t++) begin
            int    h, b;
            bit    pos;
            string req;
            if (t > 0) @(negedge clk);
            check_clocks();
            h = t / HALF;
            if (h < 6) begin
                pos = cmd ? (h < 3) : (h >= 3);
                req = (t == 0) ? "R3" : "R4";
            end else if (h < 38) begin
                pos = d[15 - (h - 6) / 2] ^ (h % 2 == 1);
                req = "R5";
            end else begin
                pos = par ^ (h % 2 == 1);
                req = "R6";
            end
            if (!drive_en) req = "R10";
            if (keep || chained) req = (h < 6) ? "R8" : req;
            chk(one_n, !(drive_en && pos), req, "bip_one_n_o");
            chk(zero_n, !(drive_en && !pos), req, "bip_zero_n_o");
            chk(one_n | zero_n, 1'b1, "R11", "both outputs low");
            chk(send_data, (t / BITC >= 2) && (t / BITC <= 17), "R7", "send_data_o");
            // next-edge stimulus
            if (t == 0) begin
                cmd_sel = !cmd;
                if (!keep) enable = 1'b0;
            end
            if (pulse && t == 100) enable = 1'b1;
            if (pulse && t == 112) enable = 1'b0;
            if (inh && t == 49) drive_en = 1'b0;
            if (inh && t == 79) drive_en = 1'b1;
            b = (t + 1) / BITC;
            if (((t + 1) % BITC) == HALF && b >= 2 && b <= 17)
                sdi = d[15 - (b - 2)];
            else
                sdi = 1'($urandom);
        end
        chained = keep;
        next_s  = s + WORD;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        chk(div6, 1'b1, "R1", "div6_o in reset");
        chk(shclk, 1'b0, "R1", "shift_clk_o in reset");
        rst = 1'b0;
        idle_cycles(30);

        // walking ones, alternating sync kind
        for (int i = 0; i < 16; i++) begin
            send_word(16'(1 << i), (i % 2) == 1, 0, 0, 0);
            idle_cycles(3);
        end
        send_word(16'h0000, 1, 0, 0, 0);
        send_word(16'hFFFF, 0, 0, 0, 0);
        send_word(16'hA5C3, 1, 0, 0, 0);
        send_word(16'h8001, 0, 0, 0, 0);
        idle_cycles(20);

        // back-to-back words (R8)
        send_word(16'h1234, 1, 1, 0, 0);
        send_word(16'hFEDC, 0, 1, 0, 0);
        send_word(16'h0F0F, 1, 0, 0, 0);
        idle_cycles(30);

        // enable pulse mid-word is ignored (R8)
        send_word(16'h5A5A, 0, 0, 1, 0);
        idle_cycles(30);

        // inhibit window (R10)
        send_word(16'hC001, 1, 0, 0, 1);
        idle_cycles(10);

        for (int i = 0; i < 8; i++) begin
            send_word(16'($urandom), 1'($urandom), 0, 0, 0);
        end
        idle_cycles(30);

        // reset in the middle of a word (R1)
        enable = 1'b1;
        cmd_sel = 1'b1;
        repeat (40) @(negedge clk);
        enable = 1'b0;
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1");
        chk(div6, 1'b1, "R1", "div6_o after reset");
        chk(shclk, 1'b0, "R1", "shift_clk_o after reset");
        @(negedge clk);
        rst = 1'b0;
        chained = 0;
        idle_cycles(30);
        send_word(16'h3C96, 0, 0, 0, 0);
        idle_cycles(12);

        finish_run();
    end
endmodule